// File: doc/BRIEF.md
# Dual-Compare Single Pulse Generator

This block produces exactly one pulse each time it is armed. Two internal up-counters with a period register serve as time bases, each with an optional divide-by-two prescaler. A select field picks one of them to feed a pair of comparators. The first comparator holds the leading-edge value and the second holds the trailing-edge value. When the selected count steps onto the leading-edge value, the output rises. When the count later steps onto the trailing-edge value, the output falls and a completion flag is raised. The output then stays low until software arms the unit again.

All configuration goes through a single write port: an address, a data word and a write strobe. Arming is done by writing the one-shot mode code into the control word. The write can be repeated at any time, with or without new compare values, and the running time base never has to be stopped or cleared. The completion flag is sticky. A dedicated strobe clears it, and it is gated by an enable to form the interrupt request.

Top module: `pulse_cmp_unit`

## Requirements
- R1: A write to address 0 with mode field bits [2:0] = 3'b100 arms the unit. The output reads low from the cycle after that write, even if a pulse was in progress.
- R2: Control bit 3 picks the time base for the comparators: 0 for timer 0 and 1 for timer 1. The unselected timer has no effect on the output.
- R3: While the unit is armed, the output goes high one cycle after the selected count steps to a value equal to the leading-edge register (address 1).
- R4: While the output is high, it goes low one cycle after the selected count steps to a value equal to the trailing-edge register (address 2). After that, no further pulse is produced until the unit is re-armed.
- R5: The trailing-edge match that ends a pulse sets the sticky flag `irq_flag`. `irq_req` is high only while the flag is set and control bit 4 (interrupt enable) is 1.
- R6: A one-cycle `flag_clr` clears the flag on the next cycle. When a completion and a clear fall in the same cycle, the flag is set.
- R7: Re-arming while a timer keeps running produces a new pulse without the timer being stopped or cleared.
- R8: With any mode code other than 3'b100, and after reset where the code is 3'b000, the output is held low, matches are ignored and the flag is never set.
- R9: Each timer has a control word (address 3 for timer 0, address 5 for timer 1) with bit 0 as enable and bit 1 as divide-by-two, and a period register (address 4 or 6). A timer advances by one per cycle only while enabled, or once every two cycles when divide-by-two is set. After equalling its period it steps to 0.
- R10: A match is recognised only in the cycle after the count changes. A stalled count that equals a compare value never triggers an edge.
- R11: If the leading-edge value is never reached, for example because it is above the period, the output stays low and no flag is set.
- R12: After reset the output, the flag, the interrupt request and both counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | CNT_W | Register write data |
| flag_clr | input | 1 | Clears the completion flag |
| pulse_out | output | 1 | Single-pulse output |
| irq_flag | output | 1 | Sticky completion flag |
| irq_req | output | 1 | Flag gated by interrupt enable |

## Verification
The directed cases cover several patterns. A plain divide-by-one run pins the exact rise and fall cycles, which shows an off-by-one anywhere in the timer or comparator chain. A divide-by-two run on timer 1 with timer 0 stopped shows the prescaler rate and also that the select field really routes the chosen count. A count stalled on the leading-edge value shows change-qualified matching against level matching. A leading-edge value above the period, a mode write that cancels a pulse mid-way, and a clear strobe held through completion exercise the paths where no pulse or no flag must appear, and the set-over-clear priority. Random runs then vary period, compare values, prescaler, source, mode codes, mid-pulse re-arms and clear strobes against a cycle model kept in the bench.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
   typedef enum logic [1:0] {
      PS_OFF   = 2'd0,
      PS_ARMED = 2'd1,
      PS_HIGH  = 2'd2,
      PS_DONE  = 2'd3
   } pcu_state_e;

   localparam logic [2:0] MODE_ONE_SHOT = 3'b100;

   localparam int ADR_CTRL     = 0;
   localparam int ADR_PRI      = 1;
   localparam int ADR_SEC      = 2;
   localparam int ADR_TMR_BASE = 3;   // timer i: ctrl at BASE+2i, period at BASE+2i+1
endpackage

// File: rtl/pcu_timer.sv
module pcu_timer #(
   parameter int CNT_W       = 16,
   parameter bit PRESCALE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_en,
   input  logic             cfg_div2,
   input  logic             per_we,
   input  logic [CNT_W-1:0] per_val,
   output logic [CNT_W-1:0] cnt,
   output logic             chg
);
   logic             en_q;
   logic [CNT_W-1:0] per_q;
   logic             tick;

   generate
      if (PRESCALE_EN) begin : g_pre
         logic div_q;
         logic ph_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= 1'b0;
               ph_q  <= 1'b0;
            end else if (cfg_we) begin
               div_q <= cfg_div2;
               ph_q  <= 1'b0;
            end else if (en_q && div_q) begin
               ph_q  <= ~ph_q;
            end
         end
         assign tick = en_q & (~div_q | ph_q);
      end else begin : g_nopre
         assign tick = en_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         per_q <= '0;
      end else begin
         if (cfg_we) en_q  <= cfg_en;
         if (per_we) per_q <= per_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         chg <= 1'b0;
      end else begin
         chg <= tick;
         if (tick) cnt <= (cnt == per_q) ? '0 : cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/pcu_pulse_fsm.sv
module pcu_pulse_fsm
   import pcu_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_we,
   input  logic             arm_single,
   input  logic [CNT_W-1:0] cnt,
   input  logic             chg,
   input  logic [CNT_W-1:0] pri,
   input  logic [CNT_W-1:0] sec,
   output pcu_state_e       st,
   output logic             pulse,
   output logic             done_evt
);
   logic hit_pri, hit_sec;

   assign hit_pri  = chg && (cnt == pri);
   assign hit_sec  = chg && (cnt == sec);
   assign done_evt = (st == PS_HIGH) && hit_sec && !arm_we;
   assign pulse    = (st == PS_HIGH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= PS_OFF;
      end else if (arm_we) begin
         st <= arm_single ? PS_ARMED : PS_OFF;
      end else begin
         case (st)
            PS_ARMED: if (hit_pri) st <= PS_HIGH;
            PS_HIGH:  if (hit_sec) st <= PS_DONE;
            default:  st <= st;
         endcase
      end
   end
endmodule

// File: rtl/pcu_flag.sv
module pcu_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end
endmodule

// File: rtl/pulse_cmp_unit.sv
module pulse_cmp_unit
   import pcu_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int NUM_TMR     = 2,
   parameter int ADDR_W      = 3,
   parameter bit PRESCALE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              flag_clr,
   output logic              pulse_out,
   output logic              irq_flag,
   output logic              irq_req
);
   localparam int SEL_W   = $clog2(NUM_TMR);
   localparam int IE_BIT  = 3 + SEL_W;
   localparam int LAST_AD = ADR_TMR_BASE + 2 * NUM_TMR - 1;

   generate
      if (NUM_TMR < 2 || (NUM_TMR & (NUM_TMR - 1)) != 0) begin : g_bad_tmr
         $error("NUM_TMR must be a power of two, at least 2");
      end
      if (CNT_W < IE_BIT + 1) begin : g_bad_width
         $error("CNT_W too narrow for the control word");
      end
      if (LAST_AD >= (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [2:0]       mode_q;
   logic [SEL_W-1:0] tsel_q;
   logic             ie_q;
   logic [CNT_W-1:0] pri_q, sec_q;
   logic             arm_we, arm_single;

   assign arm_we     = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
   assign arm_single = (wr_data[2:0] == MODE_ONE_SHOT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         tsel_q <= '0;
         ie_q   <= 1'b0;
         pri_q  <= '0;
         sec_q  <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(ADR_CTRL)) begin
            mode_q <= wr_data[2:0];
            tsel_q <= wr_data[3 +: SEL_W];
            ie_q   <= wr_data[IE_BIT];
         end
         if (wr_addr == ADDR_W'(ADR_PRI)) pri_q <= wr_data;
         if (wr_addr == ADDR_W'(ADR_SEC)) sec_q <= wr_data;
      end
   end

   logic [CNT_W-1:0] tmr_cnt [NUM_TMR];
   logic             tmr_chg [NUM_TMR];

   generate
      for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
         logic ctl_we, prd_we;
         assign ctl_we = wr_en && (wr_addr == ADDR_W'(ADR_TMR_BASE + 2 * i));
         assign prd_we = wr_en && (wr_addr == ADDR_W'(ADR_TMR_BASE + 2 * i + 1));
         pcu_timer #(.CNT_W(CNT_W), .PRESCALE_EN(PRESCALE_EN)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (ctl_we),
            .cfg_en   (wr_data[0]),
            .cfg_div2 (wr_data[1]),
            .per_we   (prd_we),
            .per_val  (wr_data),
            .cnt      (tmr_cnt[i]),
            .chg      (tmr_chg[i])
         );
      end
   endgenerate

   logic [CNT_W-1:0] cnt_sel;
   logic             chg_sel;
   assign cnt_sel = tmr_cnt[tsel_q];
   assign chg_sel = tmr_chg[tsel_q];

   pcu_state_e st;
   logic       done_evt;

   pcu_pulse_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm_we     (arm_we),
      .arm_single (arm_single),
      .cnt        (cnt_sel),
      .chg        (chg_sel),
      .pri        (pri_q),
      .sec        (sec_q),
      .st         (st),
      .pulse      (pulse_out),
      .done_evt   (done_evt)
   );

   pcu_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (done_evt),
      .clr   (flag_clr),
      .flag  (irq_flag)
   );

   assign irq_req = irq_flag & ie_q;
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker
   import pcu_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             arm_we,
   input logic             arm_single,
   input logic [2:0]       mode_q,
   input pcu_state_e       st,
   input logic [CNT_W-1:0] cnt_sel,
   input logic             chg_sel,
   input logic [CNT_W-1:0] pri_q,
   input logic [CNT_W-1:0] sec_q,
   input logic             pulse_out,
   input logic             irq_flag,
   input logic             flag_clr
);
   a_r1_arm_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_we && arm_single) |=> (!pulse_out && st == PS_ARMED));

   a_r3_rise_on_primary: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulse_out) |-> $past(chg_sel && cnt_sel == pri_q));

   a_r4_fall_on_secondary: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pulse_out) |-> $past(arm_we || (chg_sel && cnt_sel == sec_q)));

   a_r4_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_DONE && !arm_we) |=> (st == PS_DONE && !pulse_out));

   a_r5_flag_on_completion: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_HIGH && chg_sel && cnt_sel == sec_q && !arm_we) |=> irq_flag);

   a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !flag_clr) |=> irq_flag);

   a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != MODE_ONE_SHOT) |-> !pulse_out);

   a_r10_no_match_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PS_ARMED && !chg_sel && !arm_we) |=> (st == PS_ARMED));
endmodule

bind pulse_cmp_unit pcu_checker #(.CNT_W(CNT_W)) u_pcu_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .arm_we     (arm_we),
   .arm_single (arm_single),
   .mode_q     (mode_q),
   .st         (st),
   .cnt_sel    (cnt_sel),
   .chg_sel    (chg_sel),
   .pri_q      (pri_q),
   .sec_q      (sec_q),
   .pulse_out  (pulse_out),
   .irq_flag   (irq_flag),
   .flag_clr   (flag_clr)
);

// File: tb/pulse_cmp_unit_bench.sv
module pulse_cmp_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        flag_clr = 1'b0;
   logic        pulse_out, irq_flag, irq_req;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   pulse_cmp_unit u_pulse_cmp_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .flag_clr(flag_clr), .pulse_out(pulse_out), .irq_flag(irq_flag), .irq_req(irq_req)
   );

   // Reference model of the requirements (state: 0 off, 1 armed, 2 high, 3 done)
   logic [15:0] m_cnt [2];
   logic        m_chg [2];
   logic        m_en  [2];
   logic        m_div [2];
   logic        m_ph  [2];
   logic [15:0] m_per [2];
   int          m_st;
   logic [2:0]  m_mode;
   logic        m_tsel, m_ie, m_flag;
   logic [15:0] m_pri, m_sec;

   task automatic model_reset();
      for (int i = 0; i < 2; i++) begin
         m_cnt[i] = 0; m_chg[i] = 0; m_en[i] = 0; m_div[i] = 0; m_ph[i] = 0; m_per[i] = 0;
      end
      m_st = 0; m_mode = 0; m_tsel = 0; m_ie = 0; m_flag = 0; m_pri = 0; m_sec = 0;
   endtask

   task automatic model_step();
      logic arm, hp, hs, done;
      int   t;
      t    = m_tsel;
      arm  = wr_en && wr_addr == 0;
      hp   = m_chg[t] && m_cnt[t] == m_pri;
      hs   = m_chg[t] && m_cnt[t] == m_sec;
      done = (m_st == 2) && hs && !arm;
      if (arm) m_st = (wr_data[2:0] == 3'b100) ? 1 : 0;
      else if (m_st == 1 && hp) m_st = 2;
      else if (m_st == 2 && hs) m_st = 3;
      if (done) m_flag = 1; else if (flag_clr) m_flag = 0;
      for (int i = 0; i < 2; i++) begin
         logic tick;
         tick = m_en[i] && (!m_div[i] || m_ph[i]);
         if (tick) m_cnt[i] = (m_cnt[i] == m_per[i]) ? 16'd0 : m_cnt[i] + 16'd1;
         m_chg[i] = tick;
         if (wr_en && wr_addr == 3 + 2 * i) begin
            m_en[i] = wr_data[0]; m_div[i] = wr_data[1]; m_ph[i] = 0;
         end else if (m_en[i] && m_div[i]) m_ph[i] = !m_ph[i];
         if (wr_en && wr_addr == 4 + 2 * i) m_per[i] = wr_data;
      end
      if (arm) begin m_mode = wr_data[2:0]; m_tsel = wr_data[3]; m_ie = wr_data[4]; end
      if (wr_en && wr_addr == 1) m_pri = wr_data;
      if (wr_en && wr_addr == 2) m_sec = wr_data;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc();
      model_step();
      @(posedge clk);
      @(negedge clk);
      chk("R3 R4 lockstep pulse_out", pulse_out, (m_st == 2));
      chk("R5 R6 lockstep irq_flag", irq_flag, m_flag);
      chk("R5 lockstep irq_req", irq_req, m_flag && m_ie);
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1; wr_addr = 3'(a); wr_data = 16'(d);
      cyc();
      wr_en = 0;
   endtask

   task automatic wait_for(input logic lvl, input int lim, output int k);
      k = 0;
      while (pulse_out !== lvl && k < lim) begin cyc(); k++; end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      int k, highs;
      void'($urandom(32'd4711));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      chk("R12 reset pulse_out", pulse_out, 0);
      chk("R12 reset irq_flag", irq_flag, 0);
      chk("R12 reset irq_req", irq_req, 0);

      // R9 R3 R4 R5: divide-by-one timer 0, period 4, edges at 2 and 4
      wr(4, 4); wr(1, 2); wr(2, 4); wr(0, 4);
      chk("R1 armed output low", pulse_out, 0);
      wr(3, 1);
      wait_for(1, 40, k);
      chk("R3 R9 rise cycles after timer enable", k, 3);
      wait_for(0, 40, k);
      chk("R4 fall cycles after rise", k, 2);
      chk("R5 flag after completion", irq_flag, 1);
      chk("R5 irq_req masked with ie=0", irq_req, 0);
      highs = 0;
      repeat (20) begin cyc(); if (pulse_out) highs++; end
      chk("R4 no further pulse while done", highs, 0);

      // R7 R6: re-arm with running timer, clear held through completion
      flag_clr = 1;
      wr(0, 4 | 16);
      chk("R6 clear strobe clears flag", irq_flag, 0);
      wait_for(1, 40, k);
      chk("R7 re-armed pulse rises", pulse_out, 1);
      wait_for(0, 40, k);
      chk("R6 set wins over clear", irq_flag, 1);
      chk("R5 irq_req with ie=1", irq_req, 1);
      cyc();
      chk("R6 held clear then clears", irq_flag, 0);
      flag_clr = 0;

      // R10: counter stalled at 2, primary set to 2
      wr(3, 0); wr(1, 2); wr(0, 4);
      highs = 0;
      repeat (10) begin cyc(); if (pulse_out) highs++; end
      chk("R10 stalled count equal to primary gives no edge", highs, 0);
      wr(3, 1);
      wait_for(1, 40, k);
      chk("R10 rise only after count returns to primary", k, 6);

      // R11: primary above period
      wait_for(0, 40, k);
      flag_clr = 1; cyc(); flag_clr = 0;
      wr(1, 9); wr(0, 4);
      highs = 0;
      repeat (30) begin cyc(); if (pulse_out) highs++; end
      chk("R11 unreachable primary keeps output low", highs, 0);
      chk("R11 unreachable primary sets no flag", irq_flag, 0);

      // R2 R9: timer 1 with divide-by-two, timer 0 stopped
      wr(3, 0); wr(6, 10); wr(1, 3); wr(2, 5); wr(0, 4 | 8);
      wr(5, 3);
      wait_for(1, 60, k);
      chk("R2 R9 rise from timer 1 at half rate", k, 7);
      wait_for(0, 60, k);
      chk("R9 fall at half rate", k, 4);

      // R8: mode 0 during a high pulse cancels it, no flag
      flag_clr = 1; cyc(); flag_clr = 0;
      wr(0, 4 | 8);
      wait_for(1, 60, k);
      wr(0, 8);
      chk("R8 mode off drops output", pulse_out, 0);
      highs = 0;
      repeat (40) begin cyc(); if (pulse_out || irq_flag) highs++; end
      chk("R8 off mode ignores matches and sets no flag", highs, 0);

      // Random runs checked in lockstep against the model
      for (int it = 0; it < 60; it++) begin
         int per, sel, lim;
         per = 3 + ($urandom % 30);
         sel = $urandom % 2;
         wr(4 + 2 * sel, per);
         wr(3 + 2 * sel, 1 | (($urandom % 2) << 1));
         wr(3 + 2 * (1 - sel), $urandom % 4);
         wr(1, $urandom % (per + 3));
         wr(2, $urandom % (per + 1));
         wr(0, (($urandom % 4 == 0) ? ($urandom % 8) : 4) | (sel << 3) | (($urandom % 2) << 4));
         lim = 4 * (per + 1) + 8;
         for (int c = 0; c < lim; c++) begin
            flag_clr = ($urandom % 8 == 0);
            if ($urandom % 50 == 0) wr(0, 4 | (sel << 3) | 16);
            else cyc();
         end
         flag_clr = 0;
      end

      finished = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end
endmodule